// File: doc/BRIEF.md
# Programming Address Pointer with Region Decode

This block is the address counter that a serial programming port uses to walk device memory. It keeps a 14-bit pointer that three strobes move: a clear (device reset or fresh entry into programming mode), an increment command, and a load-configuration command. From the pointer it produces the index into the implemented flash words, the byte index for data EEPROM access, a one-hot tag that names the region being addressed, and write qualifiers for the identification and configuration words.

User space covers the lower half of the pointer range. Only 4K words are built, so the upper part of user space folds onto the same words. After the pointer's top bit has been set, either by loading the configuration base or by counting past the end of user space, it stays set. Counting then wraps inside configuration space, and only a clear brings the pointer back to user memory. Configuration offsets outside the 32-word window also fall through to the flash words. The region tag and write qualifiers are registered, so they describe the pointer as it stood one cycle earlier.

Top module: `prog_addr_ptr`

## Requirements
- R1: After rst_n or a clear_i strobe, ptr_o is 0x0000. After reset, region_o is 6'b000001 (user), and id_wen_o and cfg_wen_o are 0.
- R2: A step_i strobe with no other strobe adds one to the pointer while bit 13 is 0, so 0x1FFF steps to 0x2000. With no strobe the pointer holds.
- R3: flash_idx_o is always the low 12 pointer bits, so 0x1000–0x1FFF address the same words as 0x0000–0x0FFF.
- R4: A cfg_load_i strobe sets the pointer to 0x2000 from any value.
- R5: Once bit 13 is set, only a clear removes it. cfg_space_o shows that bit, and stepping from 0x3FFF gives 0x2000.
- R6: region_o is one-hot with bit 0 = user flash, bit 1 = ID, bit 2 = device ID, bit 3 = config word, bit 4 = reserved and bit 5 = data EEPROM. In configuration space, offsets 0x00–0x03 are ID, 0x06 is device ID, 0x07 and 0x08 are config words, and 0x04, 0x05 and 0x09–0x1F are reserved.
- R7: Configuration-space pointers with offset 0x20 or above tag as user flash.
- R8: While ee_sel_i is 1 the tag is data EEPROM. ee_idx_o is always the low 8 pointer bits.
- R9: clear_i takes priority over cfg_load_i and step_i in the same cycle.
- R10: cfg_load_i takes priority over step_i in the same cycle.
- R11: region_o, id_wen_o and cfg_wen_o in a cycle decode the pointer and ee_sel_i of the cycle before.
- R12: id_wen_o is 1 only on ID offsets. cfg_wen_o[0] is 1 only at 0x2007 and cfg_wen_o[1] only at 0x2008. All of them are 0 while ee_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Device reset / programming-entry clear strobe |
| step_i | input | 1 | Increment-address strobe |
| cfg_load_i | input | 1 | Load-configuration strobe |
| ee_sel_i | input | 1 | Access targets data EEPROM |
| ptr_o | output | 14 | Current pointer |
| cfg_space_o | output | 1 | Sticky configuration-space bit |
| flash_idx_o | output | 12 | Physical flash word index |
| ee_idx_o | output | 8 | Data EEPROM byte index |
| region_o | output | 6 | One-hot region tag (registered) |
| id_wen_o | output | 1 | ID word write qualifier (registered) |
| cfg_wen_o | output | 2 | Config word 1/2 write qualifiers (registered) |

## Verification
The bench steps through the whole 16K pointer space without a break. It checks every value across the 0x1FFF-to-0x2000 crossing and the 0x3FFF wrap. A design that wrapped to zero there would leave configuration space, and one that dropped the sticky bit would return to user memory. Every configuration offset is checked against its region, including the fall-through above 0x201F and the lagged tag timing. A decoder that mis-sized the 32-word window, or that registered the tag with no lag or with two cycles of lag, would give the wrong tag at some pointer. Strobes are also paired in the same cycle to catch a wrong priority order, and a data-EEPROM sweep confirms that the tag and write qualifiers change when ee_sel_i is raised.

// File: rtl/prog_ptr_pkg.sv
package prog_ptr_pkg;
   localparam int REGION_N = 6;

   typedef enum int unsigned {
      RG_USER  = 0,
      RG_ID    = 1,
      RG_DEVID = 2,
      RG_CFGW  = 3,
      RG_RSVD  = 4,
      RG_EE    = 5
   } region_e;

   typedef logic [REGION_N-1:0] region_t;

   typedef struct packed {
      region_t    region;
      logic       id_wen;
      logic [1:0] cfg_wen;
   } tag_t;

   localparam region_t REGION_RESET = region_t'(1) << RG_USER;
endpackage

// File: rtl/prog_ptr_counter.sv
module prog_ptr_counter #(
   parameter int PTR_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load_cfg,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   localparam int TOP = PTR_W - 1;
   localparam logic [PTR_W-1:0] CFG_BASE = {1'b1, {TOP{1'b0}}};
   localparam logic [PTR_W-1:0] ONE_FULL = PTR_W'(1);
   localparam logic [TOP-1:0]   ONE_LOW  = TOP'(1);

   logic [PTR_W-1:0] ptr_nxt;
   logic [PTR_W-1:0] ptr_inc;

   // once the top bit is set only the low field advances
   always_comb begin
      if (ptr[TOP]) ptr_inc = {1'b1, ptr[TOP-1:0] + ONE_LOW};
      else          ptr_inc = ptr + ONE_FULL;
   end

   always_comb begin
      if (clear)         ptr_nxt = '0;
      else if (load_cfg) ptr_nxt = CFG_BASE;
      else if (step)     ptr_nxt = ptr_inc;
      else               ptr_nxt = ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nxt;
   end
endmodule

// File: rtl/prog_ptr_decode.sv
module prog_ptr_decode
   import prog_ptr_pkg::*;
#(
   parameter int PTR_W      = 14,
   parameter int CFG_SPAN_W = 5,
   parameter int ID_COUNT   = 4,
   parameter int DEVID_OFS  = 6,
   parameter int CFG1_OFS   = 7,
   parameter int CFG2_OFS   = 8
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic             ee_sel,
   output tag_t             tag
);
   localparam int TOP = PTR_W - 1;

   logic                  in_cfg;
   logic                  in_win;
   logic [CFG_SPAN_W-1:0] ofs;
   logic [ID_COUNT-1:0]   id_hit;

   assign in_cfg = ptr[TOP];
   assign ofs    = ptr[CFG_SPAN_W-1:0];
   assign in_win = (ptr[TOP-1:CFG_SPAN_W] == '0);

   for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
      assign id_hit[g] = (ofs == CFG_SPAN_W'(g));
   end

   always_comb begin
      tag = '0;
      if (ee_sel) begin
         tag.region[RG_EE] = 1'b1;
      end else if (!in_cfg || !in_win) begin
         tag.region[RG_USER] = 1'b1;
      end else if (|id_hit) begin
         tag.region[RG_ID] = 1'b1;
         tag.id_wen        = 1'b1;
      end else if (ofs == CFG_SPAN_W'(DEVID_OFS)) begin
         tag.region[RG_DEVID] = 1'b1;
      end else if (ofs == CFG_SPAN_W'(CFG1_OFS)) begin
         tag.region[RG_CFGW] = 1'b1;
         tag.cfg_wen[0]      = 1'b1;
      end else if (ofs == CFG_SPAN_W'(CFG2_OFS)) begin
         tag.region[RG_CFGW] = 1'b1;
         tag.cfg_wen[1]      = 1'b1;
      end else begin
         tag.region[RG_RSVD] = 1'b1;
      end
   end
endmodule

// File: rtl/prog_ptr_tagreg.sv
module prog_ptr_tagreg
   import prog_ptr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  tag_t tag_d,
   output tag_t tag_q
);
   localparam tag_t TAG_RESET = '{region: REGION_RESET, id_wen: 1'b0, cfg_wen: 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= TAG_RESET;
      else        tag_q <= tag_d;
   end
endmodule

// File: rtl/prog_addr_ptr.sv
module prog_addr_ptr
   import prog_ptr_pkg::*;
#(
   parameter int PTR_W      = 14,
   parameter int FLASH_AW   = 12,
   parameter int EE_AW      = 8,
   parameter int CFG_SPAN_W = 5,
   parameter int ID_COUNT   = 4,
   parameter int DEVID_OFS  = 6,
   parameter int CFG1_OFS   = 7,
   parameter int CFG2_OFS   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                step_i,
   input  logic                cfg_load_i,
   input  logic                ee_sel_i,
   output logic [PTR_W-1:0]    ptr_o,
   output logic                cfg_space_o,
   output logic [FLASH_AW-1:0] flash_idx_o,
   output logic [EE_AW-1:0]    ee_idx_o,
   output logic [REGION_N-1:0] region_o,
   output logic                id_wen_o,
   output logic [1:0]          cfg_wen_o
);
   localparam int TOP = PTR_W - 1;

   if (FLASH_AW > TOP) begin : g_bad_flash
      $error("FLASH_AW must fit below the configuration-space bit");
   end
   if (EE_AW > FLASH_AW) begin : g_bad_ee
      $error("EE_AW must not exceed FLASH_AW");
   end
   if (CFG_SPAN_W >= TOP) begin : g_bad_span
      $error("CFG_SPAN_W must be narrower than the user field");
   end
   if (ID_COUNT > DEVID_OFS || DEVID_OFS >= CFG1_OFS || CFG1_OFS >= CFG2_OFS
       || CFG2_OFS >= (1 << CFG_SPAN_W)) begin : g_bad_map
      $error("configuration offsets must ascend inside the window");
   end

   logic [PTR_W-1:0] ptr;
   tag_t             tag_d;
   tag_t             tag_q;

   prog_ptr_counter #(.PTR_W(PTR_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear_i),
      .load_cfg (cfg_load_i),
      .step     (step_i),
      .ptr      (ptr)
   );

   prog_ptr_decode #(
      .PTR_W      (PTR_W),
      .CFG_SPAN_W (CFG_SPAN_W),
      .ID_COUNT   (ID_COUNT),
      .DEVID_OFS  (DEVID_OFS),
      .CFG1_OFS   (CFG1_OFS),
      .CFG2_OFS   (CFG2_OFS)
   ) u_dec (
      .ptr    (ptr),
      .ee_sel (ee_sel_i),
      .tag    (tag_d)
   );

   prog_ptr_tagreg u_tag (
      .clk   (clk),
      .rst_n (rst_n),
      .tag_d (tag_d),
      .tag_q (tag_q)
   );

   assign ptr_o       = ptr;
   assign cfg_space_o = ptr[TOP];
   assign flash_idx_o = ptr[FLASH_AW-1:0];
   assign ee_idx_o    = ptr[EE_AW-1:0];
   assign region_o    = tag_q.region;
   assign id_wen_o    = tag_q.id_wen;
   assign cfg_wen_o   = tag_q.cfg_wen;
endmodule

// File: rtl/prog_addr_ptr_chk.sv
module prog_addr_ptr_chk #(
   parameter int PTR_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_i,
   input logic             step_i,
   input logic             cfg_load_i,
   input logic             ee_sel_i,
   input logic [PTR_W-1:0] ptr_o,
   input logic             cfg_space_o,
   input logic [5:0]       region_o,
   input logic             id_wen_o,
   input logic [1:0]       cfg_wen_o
);
   localparam logic [PTR_W-1:0] CFG_BASE = {1'b1, {(PTR_W-1){1'b0}}};

   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> ptr_o == '0);

   a_r10_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && cfg_load_i) |=> ptr_o == CFG_BASE);

   a_r5_sticky_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_space_o && !clear_i) |=> cfg_space_o);

   a_r2_user_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !cfg_load_i && step_i && !cfg_space_o) |=> ptr_o == $past(ptr_o) + 1'b1);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !cfg_load_i && !step_i) |=> $stable(ptr_o));

   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(region_o) == 1);

   a_r8_ee_tag: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sel_i |=> region_o == 6'b100000);

   a_r12_cfg_wen_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wen_o != 2'b00) |-> (region_o[3] && $onehot0(cfg_wen_o)));

   a_r12_id_wen_tag: assert property (@(posedge clk) disable iff (!rst_n)
      id_wen_o |-> region_o[1]);
endmodule

bind prog_addr_ptr prog_addr_ptr_chk #(.PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear_i     (clear_i),
   .step_i      (step_i),
   .cfg_load_i  (cfg_load_i),
   .ee_sel_i    (ee_sel_i),
   .ptr_o       (ptr_o),
   .cfg_space_o (cfg_space_o),
   .region_o    (region_o),
   .id_wen_o    (id_wen_o),
   .cfg_wen_o   (cfg_wen_o)
);

// File: tb/prog_addr_ptr_test.sv
`timescale 1ns/1ps
module prog_addr_ptr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear_i = 1'b0;
   logic        step_i = 1'b0;
   logic        cfg_load_i = 1'b0;
   logic        ee_sel_i = 1'b0;
   logic [13:0] ptr_o;
   logic        cfg_space_o;
   logic [11:0] flash_idx_o;
   logic [7:0]  ee_idx_o;
   logic [5:0]  region_o;
   logic        id_wen_o;
   logic [1:0]  cfg_wen_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   prog_addr_ptr uut (
      .clk (clk), .rst_n (rst_n), .clear_i (clear_i), .step_i (step_i),
      .cfg_load_i (cfg_load_i), .ee_sel_i (ee_sel_i), .ptr_o (ptr_o),
      .cfg_space_o (cfg_space_o), .flash_idx_o (flash_idx_o), .ee_idx_o (ee_idx_o),
      .region_o (region_o), .id_wen_o (id_wen_o), .cfg_wen_o (cfg_wen_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int nxt(input int p);
      if (p >= 'h2000) return (p == 'h3FFF) ? 'h2000 : p + 1;
      return p + 1;
   endfunction

   function automatic int exp_region(input int p, input bit ee);
      int off;
      if (ee) return 'h20;
      if (p < 'h2000) return 'h01;
      off = p - 'h2000;
      if (off >= 32) return 'h01;
      if (off < 4) return 'h02;
      if (off == 6) return 'h04;
      if (off == 7 || off == 8) return 'h08;
      return 'h10;
   endfunction

   function automatic int exp_flags(input int p, input bit ee);
      int f = 0;
      if (!ee && p >= 'h2000 && p < 'h2004) f += 4;
      if (!ee && p == 'h2007) f += 1;
      if (!ee && p == 'h2008) f += 2;
      return f;
   endfunction

   function automatic int act_flags();
      return int'({id_wen_o, cfg_wen_o});
   endfunction

   // one strobe cycle; leaves inputs idle and samples on the next falling edge
   task automatic strobe(input bit c, input bit l, input bit s);
      clear_i = c; cfg_load_i = l; step_i = s;
      @(posedge clk); @(negedge clk);
      clear_i = 1'b0; cfg_load_i = 1'b0; step_i = 1'b0;
   endtask

   task automatic tag_check(input int p, input bit ee, input string req);
      @(posedge clk); @(negedge clk);
      check(region_o == 6'(exp_region(p, ee)), req, int'(region_o), exp_region(p, ee));
      check(act_flags() == exp_flags(p, ee), "R12", act_flags(), exp_flags(p, ee));
   endtask

   initial begin
      int expv;
      int prev;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ptr_o == 14'h0, "R1", int'(ptr_o), 0);
      check(region_o == 6'h01, "R1", int'(region_o), 1);
      check(act_flags() == 0, "R1", act_flags(), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep: user space, alias, boundary, config space, wrap
      expv = 0;
      step_i = 1'b1;
      for (int i = 0; i < 16392; i++) begin
         @(posedge clk); @(negedge clk);
         prev = expv;
         expv = nxt(expv);
         check(ptr_o == 14'(expv), "R2/R5 step", int'(ptr_o), expv);
         check(flash_idx_o == 12'(expv & 'hFFF), "R3 alias", int'(flash_idx_o), expv & 'hFFF);
         check(cfg_space_o == (expv >= 'h2000), "R5 sticky", int'(cfg_space_o), int'(expv >= 'h2000));
         check(region_o == 6'(exp_region(prev, 1'b0)), "R6/R7/R11 region", int'(region_o),
               exp_region(prev, 1'b0));
         check(act_flags() == exp_flags(prev, 1'b0), "R12 flags", act_flags(), exp_flags(prev, 1'b0));
      end
      step_i = 1'b0;
      @(negedge clk);
      check(ptr_o == 14'(expv), "R2 hold", int'(ptr_o), expv);

      // R9 clear returns from config space and beats the other strobes
      strobe(1'b1, 1'b1, 1'b1);
      check(ptr_o == 14'h0, "R9", int'(ptr_o), 0);
      check(cfg_space_o == 1'b0, "R9", int'(cfg_space_o), 0);
      tag_check(0, 1'b0, "R9");

      // R4 load from user space
      strobe(1'b0, 1'b0, 1'b1);
      strobe(1'b0, 1'b0, 1'b1);
      strobe(1'b0, 1'b1, 1'b0);
      check(ptr_o == 14'h2000, "R4", int'(ptr_o), 'h2000);
      tag_check('h2000, 1'b0, "R4");

      // R10 load beats step, even deep in config space
      strobe(1'b0, 1'b0, 1'b1);
      strobe(1'b0, 1'b1, 1'b1);
      check(ptr_o == 14'h2000, "R10", int'(ptr_o), 'h2000);
      strobe(1'b1, 1'b0, 1'b1);
      check(ptr_o == 14'h0, "R9 clear vs step", int'(ptr_o), 0);

      // R8 data EEPROM sweep
      ee_sel_i = 1'b1;
      expv = 0;
      for (int i = 0; i < 300; i++) begin
         strobe(1'b0, 1'b0, 1'b1);
         expv = nxt(expv);
         check(ee_idx_o == 8'(expv & 'hFF), "R8 ee index", int'(ee_idx_o), expv & 'hFF);
         check(region_o == 6'h20, "R8 ee region", int'(region_o), 'h20);
      end
      strobe(1'b0, 1'b1, 1'b0);
      check(region_o == 6'h20, "R8 ee in cfg", int'(region_o), 'h20);
      check(act_flags() == 0, "R12 ee flags", act_flags(), 0);
      ee_sel_i = 1'b0;
      repeat (7) strobe(1'b0, 1'b0, 1'b1);
      tag_check('h2007, 1'b0, "R12 cfg1");

      // R1 synchronous clear restores the reset view
      strobe(1'b1, 1'b0, 1'b0);
      tag_check(0, 1'b0, "R1 clear");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule